// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a bit sampler and a frame parser on the receive side of a CAN controller. Each sampled bus bit arrives with a valid strobe. The block removes the stuff bits that the transmitter inserted and passes on only the real frame bits. Each forwarded bit carries its own strobe and its position in the frame. Position 0 is the start-of-frame bit. A removed stuff bit raises a separate one-cycle flag and does not take a frame position.

The stuff decision looks at the raw bit stream, stuff bits included. A stuff bit can therefore be the first bit of a new run. Once the parser has decoded the data length, it supplies the index of the last data bit. Destuffing then stays active only up to the end of the CRC sequence. From the CRC delimiter onward, every bit is forwarded unchanged. Six equal raw bits while destuffing is active raise a stuff-error pulse. The parser pulses a clear input when a frame ends or is abandoned.

Top module: `can_destuffer`

## Requirements
- R1: After reset, out_valid, stuff_seen and stuff_error are 0 and out_idx is 0.
- R2: An accepted raw bit whose previous five raw bits (all since the last clear) are equal and which differs from them is a stuff bit. One cycle later stuff_seen is 1 and out_valid is 0.
- R3: The run history is built from raw bits, stuff bits included. For example, 0,0,0,0,0,1 (stuff), 1,1,1,1 makes the next 0 a stuff bit.
- R4: out_idx is 0 for the first forwarded bit after a clear or reset, and rises by one for each forwarded bit. Stuff bits do not advance it.
- R5: Every accepted non-stuff bit appears one cycle later with out_valid=1 and out_bit equal to the input bit.
- R6: When lim_known=1, destuffing and error checking apply only while the frame position of the incoming bit is below lim_idx+16. At or beyond that position, bits are forwarded whatever the history, with no stuff or error flag.
- R7: While lim_known=0, destuffing stays active at every frame position.
- R8: An accepted bit equal to the previous five equal raw bits, while destuffing is active, gives a one-cycle stuff_error together with its normal forwarding (out_valid=1).
- R9: clr empties the history and sets the frame position to 0. An in_valid in the same cycle is dropped, and the next cycle shows no output strobe.
- R10: A cycle with in_valid=0 gives no out_valid, stuff_seen or stuff_error in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Frame clear from the parser (frame end or abort) |
| in_valid | input | 1 | Raw sampled bit strobe |
| in_bit | input | 1 | Raw sampled bit (0 = dominant) |
| lim_known | input | 1 | Last data bit index is valid |
| lim_idx | input | IDX_W | Frame index of the last data bit |
| out_valid | output | 1 | Forwarded frame bit strobe |
| out_bit | output | 1 | Forwarded frame bit |
| out_idx | output | IDX_W | Frame position of the forwarded bit |
| stuff_seen | output | 1 | Pulse: a stuff bit was removed |
| stuff_error | output | 1 | Pulse: six equal raw bits while destuffing |

## Verification
The bench builds the block with its defaults: an 8-bit frame index and a run length of five. It sweeps all 1024 ten-bit raw patterns after a clear, which covers every run, stuff and six-equal case near the start of a frame. Striped patterns with run lengths of four to seven are then sent for last-data-bit values 0 to 3. This makes the switch-off point at positions 16 to 19 fall both inside and just outside a run. A bench model tracks run length and value instead of a bit history, and directed sequences cover chained stuff bits, a clear colliding with a bit, and idle cycles.

// File: rtl/can_dstf_pkg.sv
package can_dstf_pkg;

  // Frame bits from the last data bit up to and including the CRC sequence
  localparam int unsigned CRC_SPAN = 16;

  // Destuffing is active while the incoming frame position is below last+CRC_SPAN
  function automatic logic window_open(input int unsigned pos,
                                       input int unsigned last_idx,
                                       input logic        last_known);
    return !last_known || (pos < last_idx + CRC_SPAN);
  endfunction

  // All bits of a run history equal
  function automatic logic run_uniform(input logic [31:0] h, input int unsigned n);
    logic [31:0] msk;
    msk = (32'd1 << n) - 32'd1;
    return ((h & msk) == 32'd0) || ((h & msk) == msk);
  endfunction

endpackage

// File: rtl/can_dstf_hist.sv
module can_dstf_hist #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift,
  input  logic               bit_in,
  output logic [RUN_LEN-1:0] hist,
  output logic               full
);
  localparam int unsigned FW = $clog2(RUN_LEN + 1);
  localparam logic [FW-1:0] FULL_CNT = FW'(RUN_LEN);

  logic [FW-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      fill <= '0;
    end else if (clr) begin
      hist <= '0;
      fill <= '0;
    end else if (shift) begin
      hist <= {hist[RUN_LEN-2:0], bit_in};
      if (fill != FULL_CNT) fill <= fill + 1'b1;
    end
  end

  assign full = (fill == FULL_CNT);
endmodule

// File: rtl/can_dstf_class.sv
module can_dstf_class #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic               en,
  input  logic               full,
  input  logic [RUN_LEN-1:0] hist,
  input  logic               bit_in,
  output logic               stuff_hit,
  output logic               six_hit
);
  logic uniform;

  always_comb begin
    uniform   = can_dstf_pkg::run_uniform(32'(hist), RUN_LEN);
    stuff_hit = en && full && uniform && (bit_in != hist[0]);
    six_hit   = en && full && uniform && (bit_in == hist[0]);
  end
endmodule

// File: rtl/can_dstf_count.sv
module can_dstf_count #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             lim_known,
  input  logic [IDX_W-1:0] lim_idx,
  output logic [IDX_W-1:0] pos,
  output logic             win_open
);
  localparam logic [IDX_W-1:0] POS_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pos <= '0;
    else if (clr)                      pos <= '0;
    else if (adv && pos != POS_MAX)    pos <= pos + 1'b1;
  end

  assign win_open = can_dstf_pkg::window_open(32'(pos), 32'(lim_idx), lim_known);
endmodule

// File: rtl/can_destuffer.sv
module can_destuffer #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned RUN_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             lim_known,
  input  logic [IDX_W-1:0] lim_idx,
  output logic             out_valid,
  output logic             out_bit,
  output logic [IDX_W-1:0] out_idx,
  output logic             stuff_seen,
  output logic             stuff_error
);
  logic               accept;
  logic               fwd_fire;
  logic               win_open;
  logic               stuff_hit;
  logic               six_hit;
  logic               hist_full;
  logic [RUN_LEN-1:0] hist;
  logic [IDX_W-1:0]   pos;

  assign accept   = in_valid && !clr;
  assign fwd_fire = accept && !stuff_hit;

  can_dstf_hist #(.RUN_LEN(RUN_LEN)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift(accept), .bit_in(in_bit),
    .hist(hist), .full(hist_full)
  );

  can_dstf_class #(.RUN_LEN(RUN_LEN)) u_class (
    .en(win_open), .full(hist_full), .hist(hist), .bit_in(in_bit),
    .stuff_hit(stuff_hit), .six_hit(six_hit)
  );

  can_dstf_count #(.IDX_W(IDX_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(fwd_fire),
    .lim_known(lim_known), .lim_idx(lim_idx), .pos(pos), .win_open(win_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_bit     <= 1'b0;
      out_idx     <= '0;
      stuff_seen  <= 1'b0;
      stuff_error <= 1'b0;
    end else begin
      out_valid   <= fwd_fire;
      stuff_seen  <= accept && stuff_hit;
      stuff_error <= accept && six_hit;
      if (fwd_fire) begin
        out_bit <= in_bit;
        out_idx <= pos;
      end
    end
  end
endmodule

// File: rtl/can_destuffer_chk.sv
module can_destuffer_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_valid,
  input logic             in_bit,
  input logic             out_valid,
  input logic             out_bit,
  input logic [IDX_W-1:0] out_idx,
  input logic             stuff_seen,
  input logic             stuff_error,
  input logic             stuff_hit,
  input logic             six_hit,
  input logic             win_open
);
  a_r2_stuff_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_seen |-> !out_valid);

  a_r8_err_still_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_error |-> out_valid && !stuff_seen);

  a_r5_fwd_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !clr && !stuff_hit |=> out_valid && (out_bit == $past(in_bit)));

  a_r6_window_shut: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> !stuff_hit && !six_hit);

  a_r9_clr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid && !stuff_seen && !stuff_error);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !stuff_seen && !stuff_error);

  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) && ($past(out_idx) != '1)
      |-> out_idx == $past(out_idx) + 1'b1);
endmodule

bind can_destuffer can_destuffer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_bit(in_bit),
  .out_valid(out_valid), .out_bit(out_bit), .out_idx(out_idx),
  .stuff_seen(stuff_seen), .stuff_error(stuff_error),
  .stuff_hit(stuff_hit), .six_hit(six_hit), .win_open(win_open)
);

// File: tb/tb_can_destuffer.sv
module tb_can_destuffer;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_bit = 1'b0;
  logic             lim_known = 1'b0;
  logic [IDX_W-1:0] lim_idx = '0;
  logic             out_valid, out_bit, stuff_seen, stuff_error;
  logic [IDX_W-1:0] out_idx;

  int n_chk = 0;
  int n_bad = 0;

  // bench model: run of equal raw bits and frame position
  int m_run = 0;
  int m_val = 0;
  int m_pos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_destuffer #(.IDX_W(IDX_W), .RUN_LEN(5)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_bit(in_bit),
    .lim_known(lim_known), .lim_idx(lim_idx), .out_valid(out_valid),
    .out_bit(out_bit), .out_idx(out_idx), .stuff_seen(stuff_seen),
    .stuff_error(stuff_error)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (valid,bit,err,stuff,idx)", tag, act, exp);
    end
  endtask

  task automatic send(input logic b, input string tag);
    bit en, stf, err;
    logic [11:0] exp;
    en  = !lim_known || (m_pos < int'(lim_idx) + 16);
    stf = en && (m_run >= 5) && (int'(b) != m_val);
    err = en && (m_run >= 5) && (int'(b) == m_val);
    exp = {!stf, stf ? 1'b0 : b, err, stf, IDX_W'(stf ? 0 : m_pos)};
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    in_valid = 1'b0;
    if (stf) check(tag, {out_valid, 1'b0, stuff_error, stuff_seen, IDX_W'(0)}, exp);
    else     check(tag, {out_valid, out_bit, stuff_error, stuff_seen, out_idx}, exp);
    if (m_run == 0 || int'(b) != m_val) begin m_val = int'(b); m_run = 1; end
    else if (m_run < 7) m_run++;
    if (!stf) m_pos++;
  endtask

  task automatic clear_frame(input logic with_bit);
    clr = 1'b1;
    in_valid = with_bit;
    in_bit = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
    check("R9 clear", {out_valid, 1'b0, stuff_error, stuff_seen, IDX_W'(0)}, 12'h000);
    m_run = 0; m_pos = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, out_bit, stuff_error, stuff_seen, out_idx}, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle", {out_valid, 1'b0, stuff_error, stuff_seen, IDX_W'(0)}, 12'h000);

    // R2 R5 R8 R7: all ten-bit patterns, limit unknown
    for (int p = 0; p < 1024; p++) begin
      clear_frame(1'b0);
      for (int i = 9; i >= 0; i--) send(p[i], "R2 R5 R8 R7 sweep");
    end

    // R3: stuff bit starts a new run
    clear_frame(1'b0);
    for (int i = 0; i < 5; i++) send(1'b0, "R3 run");
    send(1'b1, "R3 first stuff");
    for (int i = 0; i < 4; i++) send(1'b1, "R3 run");
    send(1'b0, "R3 chained stuff");
    send(1'b0, "R4 index after stuff");

    // R9: clear collides with a bit, then R4 restarts at 0
    for (int i = 0; i < 3; i++) send(1'b1, "R5 pre-clear");
    clear_frame(1'b1);
    send(1'b1, "R4 index restart");

    // R10: idle gaps in a run do not disturb it
    clear_frame(1'b0);
    for (int i = 0; i < 5; i++) begin
      send(1'b1, "R10 gapped run");
      @(negedge clk);
      check("R10 idle", {out_valid, 1'b0, stuff_error, stuff_seen, IDX_W'(0)}, 12'h000);
    end
    send(1'b0, "R2 gapped stuff");

    // R6: switch-off window for several last-data-bit values and run lengths
    lim_known = 1'b1;
    for (int l = 0; l < 4; l++) begin
      lim_idx = IDX_W'(l);
      for (int k = 4; k <= 7; k++) begin
        clear_frame(1'b0);
        for (int i = 0; i < 40; i++) send(((i / k) % 2) == 1, "R6 window");
      end
      clear_frame(1'b0);
      for (int i = 0; i < 30; i++) send(1'b1, "R6 window ones");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule